// File: doc/BRIEF.md
# Wait-State Chip-Select External Bus Controller

This block turns single-beat read and write requests from a processor into timed bus cycles for asynchronous SRAM or ROM. It decodes the 24-bit request address into eight 1 MiB chip-select regions. It then walks each access through eight bus phases. Each phase is one half of a bus clock, and the block drives an active-low chip select, output enable and write enable at fixed phase positions. Each region holds its own wait-state count and separate read and write permission bits. A small configuration port writes those settings. Every wait state replays phases 5 and 6 once, which lengthens the cycle and both strobe windows by one full bus clock.

The block runs on `clk`, which is four times the bus clock. One phase is therefore two `clk` periods, so the strobe edges can fall mid-phase. The requester raises `req` with its address, direction and write data, and holds them until `ack` pulses for one cycle. `ack_err` reports an access that was refused. `ack_rdata` returns read data captured at the last `clk` edge before the output-enable window closes.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and directly after it, all chip selects, `mem_oe_n` and `mem_we_n` are high, and `ack` and `mem_dout_en` are low.
- R2: After reset every region has 15 wait states with reads and writes allowed. A read to any mapped region then shows `ack` in the 77th cycle after the accepting edge, and `mem_oe_n` is low for 70 cycles.
- R3: For a zero-wait read, cycles are counted from the accepting edge as tick 0. The strobe is low from tick 5 (middle of phase 3) through tick 14, which is 10 cycles, and `ack` is seen in the 17th cycle.
- R4: Each configured wait state adds 4 `clk` cycles to the strobe-low window and to the time until `ack`. A region with w waits gives 10+4w strobe cycles.
- R5: Read data on `mem_din` at the final strobe-low cycle is returned on `ack_rdata` together with `ack`.
- R6: Request bits [22:20] select chip select `mem_cs_n[n]`, which is the only one low while strobes are active. A request with bit 23 set maps to no region. It is refused with `ack` and `ack_err` in the next cycle and produces no strobe.
- R7: A read to a region whose read permission is clear is refused with `ack_err` in the next cycle and no strobe. The same holds for a write to a region whose write permission is clear.
- R8: `mem_oe_n` and `mem_we_n` are never low together, and at most one chip select is low at any time.
- R9: A write drives `mem_we_n` over the same window as the read strobe. `mem_dout_en` is high from the first write-strobe cycle until 2 cycles (half a bus clock) after `mem_we_n` rises, which is 12+4w cycles. `ack` follows in cycle 18+4w.
- R10: `mem_addr` equals request bits [19:0] throughout the strobe window.
- R11: A configuration write (`cfg_we`, `cfg_sel`, `cfg_wait`, `cfg_rd_en`, `cfg_wr_en`) changes only the selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, four times the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Access refused (unmapped or not permitted) |
| ack_rdata | output | 8 | Captured read data |
| cfg_we | input | 1 | Write one region's settings |
| cfg_sel | input | 3 | Region being configured |
| cfg_wait | input | 4 | Wait-state count 0..15 |
| cfg_rd_en | input | 1 | Read permission |
| cfg_wr_en | input | 1 | Write permission |
| mem_addr | output | 20 | Device address |
| mem_cs_n | output | 8 | Active-low chip selects, one per region |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 8 | Write data toward memory |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | 8 | Read data from memory |

## Verification
The assertions assume that a requester keeps `req` and its address, direction and data unchanged from the accepting edge until it sees `ack`, and that it drops `req` before the block returns to idle with `ack` still high. The bench drives every input on the falling edge and releases `req` on the same sample where it sees `ack`. It changes the configuration only between accesses, so each cycle's wait count and permissions are the ones the bench's own model holds. The memory model answers reads combinationally from the address while a chip select is low and returns a distinct filler value otherwise, so a capture at the wrong moment shows up as wrong data.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW    = 24,
  parameter int DW    = 8,
  parameter int NREG  = 8,
  parameter int RBITS = 20,
  parameter int WBITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    req_wr,
  input  logic [AW-1:0]           req_addr,
  input  logic [DW-1:0]           req_wdata,
  output logic                    ack,
  output logic                    ack_err,
  output logic [DW-1:0]           ack_rdata,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_sel,
  input  logic [WBITS-1:0]        cfg_wait,
  input  logic                    cfg_rd_en,
  input  logic                    cfg_wr_en,
  output logic [RBITS-1:0]        mem_addr,
  output logic [NREG-1:0]         mem_cs_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [DW-1:0]           mem_dout,
  output logic                    mem_dout_en,
  input  logic [DW-1:0]           mem_din
);
  localparam int RSEL = $clog2(NREG);
  localparam int UB   = AW - RBITS - RSEL;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  st_t              st;
  logic [2:0]       ph;
  logic             hf;
  logic [WBITS-1:0] wrem;
  logic             wr_q;
  logic [RSEL-1:0]  rg;
  logic [RBITS-1:0] addr_q;
  logic [DW-1:0]    wd_q;

  logic [WBITS-1:0] wait_q [NREG];
  logic [NREG-1:0]  rd_ok_q, wr_ok_q;

  wire [RSEL-1:0] req_rg  = req_addr[RBITS +: RSEL];
  wire            req_hit = (req_addr[AW-1 -: UB] == '0);
  wire            req_ok  = req_hit && (req_wr ? wr_ok_q[req_rg] : rd_ok_q[req_rg]);
  wire            start   = (st == S_IDLE) && req && !ack;
  wire            strobe  = (st == S_RUN) &&
                            ((ph == 3'd2 && hf) || (ph >= 3'd3 && ph <= 3'd6) || (ph == 3'd7 && !hf));
  wire            ce      = (st == S_RUN) && (ph >= 3'd3 || (ph == 3'd2 && hf));
  wire            last    = (st == S_RUN) && ph == 3'd7 && hf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wait_q[i] <= '1;
      rd_ok_q   <= '1;
      wr_ok_q   <= '1;
      st        <= S_IDLE;
      ph        <= '0;
      hf        <= 1'b0;
      wrem      <= '0;
      wr_q      <= 1'b0;
      rg        <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      ack       <= 1'b0;
      ack_err   <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack     <= 1'b0;
      ack_err <= 1'b0;
      if (cfg_we) begin
        wait_q[cfg_sel]  <= cfg_wait;
        rd_ok_q[cfg_sel] <= cfg_rd_en;
        wr_ok_q[cfg_sel] <= cfg_wr_en;
      end
      case (st)
        S_IDLE: if (start) begin
          if (req_ok) begin
            st     <= S_RUN;
            ph     <= '0;
            hf     <= 1'b0;
            wrem   <= wait_q[req_rg];
            wr_q   <= req_wr;
            rg     <= req_rg;
            addr_q <= req_addr[RBITS-1:0];
            wd_q   <= req_wdata;
          end else begin
            ack     <= 1'b1;
            ack_err <= 1'b1;
          end
        end
        S_RUN: begin
          hf <= ~hf;
          if (!wr_q && ph == 3'd7 && !hf) ack_rdata <= mem_din;
          if (hf) begin
            if (ph == 3'd5 && wrem != '0) begin
              ph   <= 3'd4;
              wrem <= wrem - 1'b1;
            end else if (ph == 3'd7) begin
              st  <= wr_q ? S_HOLD : S_IDLE;
              ack <= !wr_q;
            end else begin
              ph <= ph + 3'd1;
            end
          end
        end
        S_HOLD: begin
          st  <= S_IDLE;
          ack <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr    = addr_q;
  assign mem_cs_n    = ce ? ~(NREG'(1) << rg) : '1;
  assign mem_oe_n    = ~(strobe && !wr_q);
  assign mem_we_n    = ~(strobe && wr_q);
  assign mem_dout    = wd_q;
  assign mem_dout_en = wr_q && ((st == S_RUN && (strobe || last)) || st == S_HOLD);

  assert_oe_we_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  assert_strobe_has_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));
  assert_err_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_err) |-> (mem_oe_n && mem_we_n && (&mem_cs_n)));
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dout_en);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic ack, ack_err;
  logic [7:0] ack_rdata;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] cfg_wait = '0;
  logic cfg_rd_en = 1'b0, cfg_wr_en = 1'b0;
  logic [19:0] mem_addr;
  logic [7:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0] mem_dout, mem_din;

  int checks = 0, errors = 0;
  logic [3:0] m_wait [8];
  logic [7:0] m_rd, m_wr;

  always #5 clk = ~clk;

  assign mem_din = (&mem_cs_n) ? 8'hEE : (mem_addr[7:0] + 8'h5A);

  sram_cycle_ctrl u0 (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] s, input logic [3:0] w, input logic r, input logic wn);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wait = w; cfg_rd_en = r; cfg_wr_en = wn;
    m_wait[s] = w; m_rd[s] = r; m_wr[s] = wn;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [23:0] a, input logic [7:0] wd);
    int n = 0, strb = 0, den = 0, bad_cs = 0, bad_addr = 0, bad_dat = 0, both = 0;
    logic err_exp;
    int w;
    err_exp = a[23] || (wr ? !m_wr[a[22:20]] : !m_rd[a[22:20]]);
    w = m_wait[a[22:20]];
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n++;
      if (!mem_oe_n && !mem_we_n) both++;
      if (!mem_oe_n || !mem_we_n) begin
        strb++;
        if (mem_cs_n != ~(8'd1 << a[22:20])) bad_cs++;
        if (mem_addr != a[19:0]) bad_addr++;
        if (!mem_we_n && mem_dout != wd) bad_dat++;
      end
      if (mem_dout_en) den++;
      if (ack) break;
    end
    req = 1'b0;
    chk(ack, "R3 ack seen", ack, 1);
    chk(both == 0, "R8 oe/we overlap", both, 0);
    chk(ack_err == err_exp, (a[23] ? "R6 unmapped err" : "R7 permission err"), ack_err, err_exp);
    if (err_exp) begin
      chk(n == 1, "R7 refuse latency", n, 1);
      chk(strb == 0, "R6 R7 no strobe on refusal", strb, 0);
    end else begin
      chk(strb == 10 + 4*w, "R4 strobe window", strb, 10 + 4*w);
      chk(bad_cs == 0, "R6 chip select", bad_cs, 0);
      chk(bad_addr == 0, "R10 address", bad_addr, 0);
      if (wr) begin
        chk(n == 18 + 4*w, "R9 write ack cycle", n, 18 + 4*w);
        chk(den == 12 + 4*w, "R9 data drive window", den, 12 + 4*w);
        chk(bad_dat == 0, "R9 write data", bad_dat, 0);
      end else begin
        chk(n == 17 + 4*w, "R3 read ack cycle", n, 17 + 4*w);
        chk(ack_rdata == a[7:0] + 8'h5A, "R5 read data", ack_rdata, a[7:0] + 8'h5A);
        chk(den == 0, "R9 no data drive on read", den, 0);
      end
    end
  endtask

  // {cfg region, cfg wait, cfg rd, cfg wr, access wr, access addr, write data}
  localparam logic [41:0] VEC [8] = '{
    {3'd0, 4'd0, 1'b1, 1'b1, 1'b0, 24'h012345, 8'h00},
    {3'd1, 4'd3, 1'b1, 1'b1, 1'b1, 24'h1ABCDE, 8'hA7},
    {3'd2, 4'd1, 1'b0, 1'b1, 1'b0, 24'h200010, 8'h00},
    {3'd2, 4'd1, 1'b0, 1'b1, 1'b1, 24'h2000FF, 8'h3C},
    {3'd7, 4'd2, 1'b1, 1'b0, 1'b1, 24'h7FFFFF, 8'h11},
    {3'd7, 4'd2, 1'b1, 1'b0, 1'b0, 24'h7FFFFF, 8'h00},
    {3'd3, 4'd0, 1'b1, 1'b1, 1'b0, 24'h800000, 8'h00},
    {3'd5, 4'd0, 1'b1, 1'b1, 1'b0, 24'h123456, 8'h00}
  };

  initial begin
    for (int i = 0; i < 8; i++) m_wait[i] = 4'd15;
    m_rd = '1; m_wr = '1;
    repeat (3) @(negedge clk);
    chk(&mem_cs_n && mem_oe_n && mem_we_n && !ack && !mem_dout_en, "R1 in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(&mem_cs_n && mem_oe_n && mem_we_n && !ack && !mem_dout_en, "R1 after reset", 0, 1);
    // R2 default wait count of 15 before any configuration
    access(1'b0, 24'h4000AB, 8'h00);
    access(1'b1, 24'h6F0001, 8'h5C);
    foreach (VEC[i]) begin
      cfg(VEC[i][41:39], VEC[i][38:35], VEC[i][34], VEC[i][33]);
      access(VEC[i][32], VEC[i][31:8], VEC[i][7:0]);
    end
    // R11 region 4 still at the reset value after other regions changed
    access(1'b0, 24'h4C0C0C, 8'h00);
    // zero-wait write back to back with a read in region 0
    access(1'b1, 24'h000001, 8'hFF);
    access(1'b0, 24'h0FFFFF, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule